// File: doc/BRIEF.md
# Interrupt Status, Enable and Clear Unit

This block collects flags from a serial engine and its transmit and receive FIFOs into one status register. Software reads that register and writes a mask into an enable register. It clears flags by writing ones to a clear register. The unit drives a single active-high level interrupt whenever any flag that is both set and enabled is present. Access is through a plain register port: a write strobe, a byte offset, write data, and combinational read data.

Two kinds of source feed the status bits. Event sources pulse and leave their bit sticky until software clears it. The all-done completion flag is one of these. Condition sources are live levels: transmit FIFO full, a 32-bit word waiting in the receive FIFO, and a byte waiting in the receive FIFO. A condition bit sets itself again on every cycle its level is high. Clearing it and then reading it back therefore shows the FIFO state at that moment. Polling software uses this clear-then-read sequence to decide whether to push or pop another item.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the status and enable registers both read 0 and irq is 0.
- R2: A one-cycle pulse on `evt_pulse[i]` at an event position sets status bit i. The bit is readable from the next cycle and stays set until cleared. The event positions are 0, 1, 2, 5, 7, 8, 9 and 12, with bit 9 the all-done flag.
- R3: Writing to offset 0x38 clears every status bit whose write-data bit is 1, effective in the next cycle. Status bits under a 0 write-data bit keep their value.
- R4: Positions 3 (transmit full), 6 (receive word available) and 11 (receive byte available) follow `cond_live`: while the level is high the bit is set again each cycle, so a read in the cycle after a clear shows the level as it was during the clear. `evt_pulse` at these positions and `cond_live` at any other position have no effect.
- R5: When a set and a clear hit the same status bit in the same cycle, the bit is 1 afterwards.
- R6: Offset 0x34 is the enable register. A write stores only the implemented positions (mask 0x1BEF), so bits 4, 10 and 13 to 31 always read 0. The register keeps its value between writes.
- R7: Status bits are recorded whatever the enable register holds.
- R8: `irq` is 1 exactly when some status bit and the matching enable bit are both 1.
- R9: Status positions 4, 10 and 13 to 31 always read 0. A write to the status offset 0x30 changes nothing. Reads of the clear offset 0x38 and of any unmapped offset return 0.
- R10: Offset 0x30 reads the status register, with the bit positions listed in R2 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr (combinational) |
| evt_pulse | input | 13 | Per-position set pulses from event sources |
| cond_live | input | 13 | Per-position live levels from condition sources |
| irq | output | 1 | Level interrupt, high when any enabled status bit is set |

## Verification
The bench checks a clear written while a FIFO condition still holds. A design that cleared unconditionally would read 0 there and mislead polling software into overfilling or over-reading a FIFO. It also drives a pulse and a clear onto the same bit in one cycle: a clear-wins design would lose that event. Partial clear masks, writes to the read-only status offset, pulses on condition positions, and levels on event positions all check for bits that leak between the two source kinds or get wiped by mistake. The interrupt is checked with the enable mask at zero, fully open, and set to one bit. This catches an output that ignores the mask or fails to record masked events.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared constants and types for the interrupt status unit.
// Assumes a 13-position source vector and byte offsets that are multiples of 4.
package irq_ctrl_pkg;

    // Number of status positions
    localparam int unsigned SRC_N = 13;

    // Positions that exist in hardware: 0-3, 5-9, 11, 12
    localparam logic [SRC_N-1:0] IMPL_MASK  = 13'h1BEF;

    // Positions fed by live conditions: 3, 6, 11
    localparam logic [SRC_N-1:0] LEVEL_MASK = 13'h0848;

    // Register offsets decoded by software
    localparam logic [7:0] OFS_STATUS = 8'h30;
    localparam logic [7:0] OFS_ENABLE = 8'h34;
    localparam logic [7:0] OFS_CLEAR  = 8'h38;

    // Register selected by the current address
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_CLEAR  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_addr_decode.sv
// Address decoder: maps a byte offset to one of the three registers.
// Assumes offsets are compared in full; anything else selects nothing.
module irq_addr_decode
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);

    // Compare the offset against each register address
    always_comb begin
        if (addr_i == A_STATUS)      sel_o = SEL_STATUS;
        else if (addr_i == A_ENABLE) sel_o = SEL_ENABLE;
        else if (addr_i == A_CLEAR)  sel_o = SEL_CLEAR;
        else                         sel_o = SEL_NONE;
    end

endmodule

// File: rtl/irq_flag_cell.sv
// One status flag: set by its source, cleared by a write-one, set wins a tie.
// Assumes set_i and clr_i are synchronous to clk.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Hold, clear or set the flag; a set in the same cycle overrides a clear
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);

    assert_clear_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/irq_status_bank.sv
// Status register: one flag cell per implemented position. Level positions
// take their set from the live condition and event positions take it from
// the pulse. Unimplemented positions are constant 0.
module irq_status_bank #(
    parameter int unsigned      N_SRC = 13,
    parameter logic [N_SRC-1:0] IMPL  = '1,
    parameter logic [N_SRC-1:0] LEVEL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] cond_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] flags_o
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_pos
        if (!IMPL[i]) begin : g_absent
            logic unused_bits;
            // Absent position: nothing is stored
            assign unused_bits = evt_i[i] ^ cond_i[i] ^ clr_i[i];
            assign flags_o[i]  = 1'b0;
        end else if (LEVEL[i]) begin : g_level
            logic unused_evt;
            assign unused_evt = evt_i[i];
            irq_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (cond_i[i]),
                .clr_i  (clr_i[i]),
                .flag_o (flags_o[i])
            );
        end else begin : g_event
            logic unused_cond;
            assign unused_cond = cond_i[i];
            irq_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (evt_i[i]),
                .clr_i  (clr_i[i]),
                .flag_o (flags_o[i])
            );
        end
    end

    assert_level_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cond_i & LEVEL) != '0) |=>
            ((flags_o & $past(cond_i & LEVEL)) == $past(cond_i & LEVEL)));

endmodule

// File: rtl/irq_enable_reg.sv
// Enable mask register: loads the implemented positions on a write and
// holds them otherwise.
module irq_enable_reg #(
    parameter int unsigned      N_SRC = 13,
    parameter logic [N_SRC-1:0] IMPL  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [N_SRC-1:0] wdata_i,
    output logic [N_SRC-1:0] en_o
);

    logic [N_SRC-1:0] en_q;

    // Load the mask on a write, keeping only implemented positions
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (wr_i) en_q <= wdata_i & IMPL;
    end

    assign en_o = en_q;

    assert_en_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_q == ($past(wdata_i) & IMPL)));

    assert_en_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_q));

endmodule

// File: rtl/irq_ctrl_unit.sv
// Interrupt status, enable and clear unit (top). Decodes register accesses,
// keeps the status and enable registers and drives a level interrupt.
// Assumes a single-cycle write strobe and combinational read data.
module irq_ctrl_unit
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [SRC_N-1:0]  evt_pulse,
    input  logic [SRC_N-1:0]  cond_live,
    output logic              irq
);

    localparam int unsigned PAD_W = DATA_W - SRC_N;

    reg_sel_e         sel;
    logic [SRC_N-1:0] status_w;
    logic [SRC_N-1:0] enable_w;
    logic [SRC_N-1:0] clr_vec;
    logic             en_wr;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:SRC_N];

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (reg_addr),
        .sel_o  (sel)
    );

    // Form the write-one-to-clear vector and the enable write strobe
    always_comb begin
        clr_vec = (reg_wr && sel == SEL_CLEAR) ? reg_wdata[SRC_N-1:0] : '0;
        en_wr   = reg_wr && (sel == SEL_ENABLE);
    end

    irq_status_bank #(
        .N_SRC (SRC_N),
        .IMPL  (IMPL_MASK),
        .LEVEL (LEVEL_MASK)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_pulse),
        .cond_i  (cond_live),
        .clr_i   (clr_vec),
        .flags_o (status_w)
    );

    irq_enable_reg #(
        .N_SRC (SRC_N),
        .IMPL  (IMPL_MASK)
    ) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr),
        .wdata_i (reg_wdata[SRC_N-1:0]),
        .en_o    (enable_w)
    );

    // Return the addressed register, zero for clear and unmapped offsets
    always_comb begin
        case (sel)
            SEL_STATUS: reg_rdata = {{PAD_W{1'b0}}, status_w};
            SEL_ENABLE: reg_rdata = {{PAD_W{1'b0}}, enable_w};
            default:    reg_rdata = '0;
        endcase
    end

    // Level interrupt from masked status
    assign irq = |(status_w & enable_w);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (status_w == '0 && enable_w == '0 && !irq));

    assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_w == '0) |-> !irq);

    assert_status_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_STATUS && evt_pulse == '0 && cond_live == '0)
            |=> (status_w == $past(status_w)));

endmodule

// File: tb/irq_ctrl_unit_tb.sv
// Scoreboard bench: a driver pushes expected reads, a monitor compares them.
module irq_ctrl_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [12:0] evt_pulse = '0;
    logic [12:0] cond_live = '0;
    logic        irq;
    logic        rd_req = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .cond_live (cond_live),
        .irq       (irq)
    );

    // Monitor: compare read data and irq against the next expected item
    always @(negedge clk) begin
        if (rd_req) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (reg_rdata !== e.data || irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         e.tag, reg_rdata, irq, e.data, e.irq);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
        reg_wr    = 1'b0;
        evt_pulse = '0;
        rd_req    = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] d,
                      input logic i, input string tag);
        exp_t e;
        cyc();
        reg_addr = a; rd_req = 1'b1;
        e.data = d; e.irq = i; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic pulse(input logic [12:0] p);
        cyc();
        evt_pulse = p;
    endtask

    task automatic reset_dut();
        cyc();
        rst_n = 1'b0;
        cyc();
        cyc();
        rst_n = 1'b1;
    endtask

    initial begin
        reset_dut();
        rd(8'h30, 32'h0, 1'b0, "R1 status after reset");
        rd(8'h34, 32'h0, 1'b0, "R1 enable after reset");

        pulse(13'h0200);
        rd(8'h30, 32'h200, 1'b0, "R2 R7 all-done recorded while masked");
        cyc(); cyc();
        rd(8'h30, 32'h200, 1'b0, "R2 all-done sticky");

        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h34, 32'h1BEF, 1'b1, "R6 enable keeps implemented bits, R8 irq");
        wr(8'h38, 32'h1);
        rd(8'h30, 32'h200, 1'b1, "R3 zero clear bits leave status");
        wr(8'h38, 32'h200);
        rd(8'h30, 32'h0, 1'b0, "R3 clear all-done, R8 irq drops");

        wr(8'h30, 32'hFFFF);
        rd(8'h30, 32'h0, 1'b0, "R9 write to status ignored");

        pulse(13'h1FFF);
        rd(8'h30, 32'h13A7, 1'b1, "R4 R9 R10 pulses on event positions only");
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h30, 32'h0, 1'b0, "R3 clear everything");

        wr(8'h34, 32'h0);
        cyc();
        cond_live = 13'h0A48;
        rd(8'h30, 32'h848, 1'b0, "R4 R7 live conditions recorded, level ignored at bit 9");
        wr(8'h38, 32'h848);
        rd(8'h30, 32'h848, 1'b0, "R4 clear while condition holds re-sets");
        wr(8'h38, 32'h848);
        cond_live = 13'h0040;
        rd(8'h30, 32'h040, 1'b0, "R4 only still-live condition returns");
        wr(8'h38, 32'hFFFF);
        cond_live = 13'h0;
        rd(8'h30, 32'h0, 1'b0, "R4 condition gone after clear");

        wr(8'h38, 32'h1);
        evt_pulse = 13'h0001;
        rd(8'h30, 32'h1, 1'b0, "R5 set beats clear");

        wr(8'h34, 32'h20);
        rd(8'h34, 32'h20, 1'b0, "R6 R8 single enable, unmasked bit not set");
        pulse(13'h0020);
        rd(8'h30, 32'h21, 1'b1, "R8 enabled bit raises irq");
        rd(8'h38, 32'h0, 1'b1, "R9 clear offset reads 0");
        rd(8'h3C, 32'h0, 1'b1, "R9 unmapped offset reads 0");

        reset_dut();
        rd(8'h30, 32'h0, 1'b0, "R1 status after mid-run reset");
        rd(8'h34, 32'h0, 1'b0, "R1 enable after mid-run reset");

        cyc();
        cyc();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule